// File: doc/BRIEF.md
# Lookahead Relational Comparator

This block decides whether one chosen relation holds between two integer operands and returns a single true/false bit. It supports ten relations: equality, inequality, and the four orderings, each in signed and unsigned form. A branch unit or a set-on-condition path uses it to turn a compare opcode into the one Boolean the instruction needs. It does not produce every relation at once and select one afterwards.

No subtraction is performed. The relation code is decoded into per-bit generate choices, a top-bit generate choice and a carry-in. Bit equality serves as the propagate term for every relation. A two-level carry-lookahead tree, over groups of 4 bits and then groups of 16 bits, ends in a short chain across the 16-bit groups. Its carry out is the answer. The signed relations differ from the unsigned ones only at the most significant bit, where the generate sense is reversed. The result is registered once so that it lines up with a pipeline stage boundary.

Top module: `relcmp_unit`

## Requirements
- R1: While `rst_n` is low, `result_o` is 0 whatever the operands and relation code.
- R2: `result_o` reflects the operands and relation code that were present at the previous rising clock edge. A change at the inputs does not appear at the output before the next edge.
- R3: Code 0 returns 1 exactly when x equals y. Code 1 returns 1 exactly when they differ.
- R4: Code 2 returns x > y and code 3 returns x >= y, with both operands read as unsigned.
- R5: Code 4 returns x < y and code 5 returns x <= y, with both operands read as unsigned.
- R6: Code 6 returns x > y and code 7 returns x >= y, with both operands read as two's-complement signed.
- R7: Code 8 returns x < y and code 9 returns x <= y, with both operands read as two's-complement signed.
- R8: Codes 10 through 15 are undefined and always return 0.
- R9: Operands that differ only in bit 0 or only in the top bit give the correct result for all ten relations. A difference in the top bit alone reverses the ordering between the signed and unsigned readings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| x_i | input | WIDTH | Left operand |
| y_i | input | WIDTH | Right operand |
| op_i | input | 4 | Relation code (0..9 defined, 10..15 undefined) |
| result_o | output | 1 | Registered truth value of the selected relation |

## Verification
Each result appears exactly one rising edge after its operands and code are applied. The bench therefore drives new inputs on a falling edge and samples `result_o` on the next falling edge, which is half a cycle after the capturing edge. To show that nothing leaks through combinationally, one check reads the output just after a new input is driven, before any edge, and expects the old value. The bound checker compares each registered result against the inputs of the previous cycle. It only starts once a full cycle has passed since reset was released.

// File: rtl/relcmp_pkg.sv
package relcmp_pkg;

    typedef enum logic [3:0] {
        REL_EQ  = 4'd0,
        REL_NE  = 4'd1,
        REL_GTU = 4'd2,
        REL_GEU = 4'd3,
        REL_LTU = 4'd4,
        REL_LEU = 4'd5,
        REL_GTS = 4'd6,
        REL_GES = 4'd7,
        REL_LTS = 4'd8,
        REL_LES = 4'd9
    } rel_op_e;

    // Generate selection for the lower bits and for the top bit, plus carry-in.
    // gx selects x & ~y as generate, gy selects ~x & y.
    typedef struct packed {
        logic lo_gx;
        logic lo_gy;
        logic hi_gx;
        logic hi_gy;
        logic cin;
    } rel_ctl_t;

    typedef struct packed {
        logic hit;
    } cmp_state_t;

    // Combine four generate/propagate pairs into one group pair {G, P}.
    function automatic logic [1:0] grp_combine4(input logic [3:0] g, input logic [3:0] p);
        logic gg;
        logic pp;
        gg = g[3]
           | (p[3] & g[2])
           | (p[3] & p[2] & g[1])
           | (p[3] & p[2] & p[1] & g[0]);
        pp = &p;
        return {gg, pp};
    endfunction

endpackage

// File: rtl/relcmp_decode.sv
module relcmp_decode
    import relcmp_pkg::*;
(
    input  logic [3:0] op,
    output rel_ctl_t   ctl
);

    always_comb begin
        ctl = '0;
        case (op)
            REL_EQ:  ctl = '{lo_gx: 1'b0, lo_gy: 1'b0, hi_gx: 1'b0, hi_gy: 1'b0, cin: 1'b1};
            REL_NE:  ctl = '{lo_gx: 1'b1, lo_gy: 1'b1, hi_gx: 1'b1, hi_gy: 1'b1, cin: 1'b0};
            REL_GTU: ctl = '{lo_gx: 1'b1, lo_gy: 1'b0, hi_gx: 1'b1, hi_gy: 1'b0, cin: 1'b0};
            REL_GEU: ctl = '{lo_gx: 1'b1, lo_gy: 1'b0, hi_gx: 1'b1, hi_gy: 1'b0, cin: 1'b1};
            REL_LTU: ctl = '{lo_gx: 1'b0, lo_gy: 1'b1, hi_gx: 1'b0, hi_gy: 1'b1, cin: 1'b0};
            REL_LEU: ctl = '{lo_gx: 1'b0, lo_gy: 1'b1, hi_gx: 1'b0, hi_gy: 1'b1, cin: 1'b1};
            REL_GTS: ctl = '{lo_gx: 1'b1, lo_gy: 1'b0, hi_gx: 1'b0, hi_gy: 1'b1, cin: 1'b0};
            REL_GES: ctl = '{lo_gx: 1'b1, lo_gy: 1'b0, hi_gx: 1'b0, hi_gy: 1'b1, cin: 1'b1};
            REL_LTS: ctl = '{lo_gx: 1'b0, lo_gy: 1'b1, hi_gx: 1'b1, hi_gy: 1'b0, cin: 1'b0};
            REL_LES: ctl = '{lo_gx: 1'b0, lo_gy: 1'b1, hi_gx: 1'b1, hi_gy: 1'b0, cin: 1'b1};
            default: ctl = '0;  // undefined codes: no generate, no carry-in -> 0
        endcase
    end

endmodule

// File: rtl/relcmp_gp_cell.sv
module relcmp_gp_cell (
    input  logic xb,
    input  logic yb,
    input  logic sel_gx,
    input  logic sel_gy,
    output logic g,
    output logic p
);

    always_comb begin
        p = ~(xb ^ yb);
        g = (sel_gx & xb & ~yb) | (sel_gy & ~xb & yb);
    end

endmodule

// File: rtl/relcmp_lookahead.sv
module relcmp_lookahead
    import relcmp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] g,
    input  logic [WIDTH-1:0] p,
    input  logic             cin,
    output logic             cout
);

    localparam int N4  = WIDTH / 4;
    localparam int N16 = WIDTH / 16;

    logic [N4-1:0]  g4;
    logic [N4-1:0]  p4;
    logic [N16-1:0] g16;
    logic [N16-1:0] p16;

    for (genvar q = 0; q < N4; q++) begin : g_lvl4
        assign {g4[q], p4[q]} = grp_combine4(g[4*q +: 4], p[4*q +: 4]);
    end

    for (genvar s = 0; s < N16; s++) begin : g_lvl16
        assign {g16[s], p16[s]} = grp_combine4(g4[4*s +: 4], p4[4*s +: 4]);
    end

    always_comb begin
        logic c;
        c = cin;
        for (int k = 0; k < N16; k++) begin
            c = g16[k] | (p16[k] & c);
        end
        cout = c;
    end

endmodule

// File: rtl/relcmp_unit.sv
module relcmp_unit
    import relcmp_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [3:0]       op_i,
    output logic             result_o
);

    localparam int MSB = WIDTH - 1;

    rel_ctl_t         ctl;
    logic [WIDTH-1:0] g_vec;
    logic [WIDTH-1:0] p_vec;
    logic             carry_out;
    cmp_state_t       state_d;
    cmp_state_t       state_q;

    relcmp_decode u_decode (
        .op  (op_i),
        .ctl (ctl)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bits
        if (i == MSB) begin : g_top
            relcmp_gp_cell u_cell (
                .xb     (x_i[i]),
                .yb     (y_i[i]),
                .sel_gx (ctl.hi_gx),
                .sel_gy (ctl.hi_gy),
                .g      (g_vec[i]),
                .p      (p_vec[i])
            );
        end else begin : g_low
            relcmp_gp_cell u_cell (
                .xb     (x_i[i]),
                .yb     (y_i[i]),
                .sel_gx (ctl.lo_gx),
                .sel_gy (ctl.lo_gy),
                .g      (g_vec[i]),
                .p      (p_vec[i])
            );
        end
    end

    relcmp_lookahead #(.WIDTH(WIDTH)) u_tree (
        .g    (g_vec),
        .p    (p_vec),
        .cin  (ctl.cin),
        .cout (carry_out)
    );

    always_comb begin
        state_d     = state_q;
        state_d.hit = carry_out;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.hit;

endmodule

// File: rtl/relcmp_unit_chk.sv
module relcmp_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] x_i,
    input logic [WIDTH-1:0] y_i,
    input logic [3:0]       op_i,
    input logic             result_o
);

    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_RESET_LOW: assert property (@(posedge clk) !rst_n |=> !result_o); // R1

    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) >= 4'd10) |-> !result_o); // R8

    AST_EQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) == 4'd0) |-> (result_o == ($past(x_i) == $past(y_i)))); // R3

    AST_GTU_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) == 4'd2) |-> (result_o == ($past(x_i) > $past(y_i)))); // R4

    AST_LTS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(op_i) == 4'd8) |->
        (result_o == ($signed($past(x_i)) < $signed($past(y_i))))); // R7

endmodule

bind relcmp_unit relcmp_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .x_i      (x_i),
    .y_i      (y_i),
    .op_i     (op_i),
    .result_o (result_o)
);

// File: tb/tb_relcmp_unit.sv
module tb_relcmp_unit;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] x_i = '0;
    logic [W-1:0] y_i = '0;
    logic [3:0]   op_i = 4'd0;
    logic         result_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    relcmp_unit #(.WIDTH(W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .x_i      (x_i),
        .y_i      (y_i),
        .op_i     (op_i),
        .result_o (result_o)
    );

    function automatic logic ref_rel(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] op);
        case (op)
            4'd0: return a == b;
            4'd1: return a != b;
            4'd2: return $unsigned(a) >  $unsigned(b);
            4'd3: return $unsigned(a) >= $unsigned(b);
            4'd4: return $unsigned(a) <  $unsigned(b);
            4'd5: return $unsigned(a) <= $unsigned(b);
            4'd6: return $signed(a) >  $signed(b);
            4'd7: return $signed(a) >= $signed(b);
            4'd8: return $signed(a) <  $signed(b);
            4'd9: return $signed(a) <= $signed(b);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0, 4'd1: return "R3";
            4'd2, 4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8, 4'd9: return "R7";
            default:    return "R8";
        endcase
    endfunction

    task automatic expect_bit(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: result %b expected %b (x=%h y=%h op=%0d)", req, act, exp, x_i, y_i, op_i);
        end
    endtask

    // Drive on a falling edge; the result is registered on the next rising edge
    // and sampled at the following falling edge.
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b, input logic [3:0] op, input string tag);
        string req;
        @(negedge clk);
        x_i  = a;
        y_i  = b;
        op_i = op;
        @(negedge clk);
        req = (tag == "") ? req_of(op) : tag;
        expect_bit(result_o, ref_rel(a, b, op), req);
    endtask

    task automatic all_ops(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
        for (int o = 0; o < 16; o++) run(a, b, 4'(o), tag);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds the output low even with a true relation applied
        x_i = 32'h1234_5678; y_i = 32'h1234_5678; op_i = 4'd0;
        repeat (3) @(negedge clk);
        expect_bit(result_o, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: registered latency
        run(32'd5, 32'd5, 4'd1, "R2");  // NE on equal -> 0
        @(negedge clk);
        op_i = 4'd0;                    // EQ on equal -> 1 after next edge
        #1;
        expect_bit(result_o, 1'b0, "R2");
        @(negedge clk);
        expect_bit(result_o, 1'b1, "R2");

        // Corner operand pairs, all sixteen codes
        all_ops(32'h0000_0000, 32'h0000_0000, "");
        all_ops(32'hFFFF_FFFF, 32'hFFFF_FFFF, "");
        all_ops(32'h0000_0000, 32'hFFFF_FFFF, "");
        all_ops(32'hFFFF_FFFF, 32'h0000_0000, "");
        all_ops(32'h8000_0000, 32'h7FFF_FFFF, "");
        all_ops(32'h7FFF_FFFF, 32'h8000_0000, "");
        // R9: single-bit differences at bit 0 and the top bit
        all_ops(32'h1357_9BDF, 32'h1357_9BDE, "R9");
        all_ops(32'h1357_9BDE, 32'h1357_9BDF, "R9");
        all_ops(32'h8246_8ACE, 32'h0246_8ACE, "R9");
        all_ops(32'h0246_8ACE, 32'h8246_8ACE, "R9");

        // Near-exhaustive sweep over small signed values, every code
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                all_ops(W'(a), W'(b), "");
            end
        end

        // Random operands, including pairs sharing upper bits
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] ra;
            logic [W-1:0] rb;
            ra = $urandom;
            rb = (n % 2 == 0) ? $urandom : (ra ^ (W'(1) << (n % W)));
            for (int o = 0; o < 10; o++) run(ra, rb, 4'(o), "");
        end

        // R1 again: asserting reset mid-run clears the output
        run(32'd9, 32'd9, 4'd0, "R3");
        rst_n = 1'b0;
        @(negedge clk);
        expect_bit(result_o, 1'b0, "R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule